// File: doc/BRIEF.md
# Guarded Clock-Multiplier Configuration Registers

This block holds the settings for a clock multiplier behind a two-step unlock. Software writes a configuration word and a control word over a small synchronous register port. Those writes only land in pending copies. The settings that actually drive the clock generator are replaced only when a two-write key is written to a dedicated key register: 0xAA first, then 0x55 as the very next bus access. Any other bus traffic between the two key writes throws the unlock away, and the pending values stay as they are until a clean key arrives.

The live configuration word is decoded into a multiplier (stored as value minus one) and a divider (stored as a power-of-two exponent). These drive registered outputs together with the enable and connect controls. A registered flag reports whether the internal oscillator frequency falls outside its legal window. That frequency is the input reference in kHz times the multiplier times twice the divider. Reads of the configuration and control registers return the live values, never the pending ones.

Top module: `pll_cfg_guard`

## Requirements
- R1: Writes to the configuration register (address 0) or the control register (address 1) change no output and no read-back value until a key commit.
- R2: A write of 0xAA to the key register (address 2), followed by a write of 0x55 to it as the next bus access, copies both pending values into the live registers at the edge of the 0x55 write. The decoded outputs follow one clock later. Idle cycles between the two key writes are allowed.
- R3: Any bus access after an 0xAA key write other than a 0x55 key write aborts the unlock: a read, a write to another address, or a key write of another value. An abort leaves the pending values in place, so a later clean key sequence commits them. A key write of 0xAA always arms the unlock again.
- R4: The multiplier output equals live configuration bits 4:0 plus one, giving a range of 1 to 32.
- R5: The divider output equals 2 raised to live configuration bits 6:5, giving 1, 2, 4 or 8.
- R6: A committed configuration of 0x23 gives a multiplier of 4 and a divider of 2.
- R7: `freq_bad` is high when osc_khz × multiplier × 2 × divider is below 156000 or above 320000. Both limits count as legal. The flag is registered one clock after its inputs.
- R8: Control bit 0 is enable and bit 1 is connect. `pll_conn` is high only when live enable, live connect and `pll_lock` are all high.
- R9: A read returns data one clock later. Address 0 returns the live configuration in bits 6:0 with bit 7 zero. Address 1 returns live control in bits 1:0 with the upper bits zero. Addresses 2 and 3 return 0.
- R10: Reset clears pending and live registers and the unlock state. Outputs then show multiplier 1, divider 1, enable 0, connect 0 and read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| osc_khz | input | 20 | Reference oscillator frequency in kHz |
| pll_lock | input | 1 | Lock indication from the analog loop |
| pll_mult | output | 6 | Live multiplier value |
| pll_div | output | 4 | Live divider value |
| pll_en | output | 1 | Live enable |
| pll_conn | output | 1 | Connect, gated by enable and lock |
| freq_bad | output | 1 | Oscillator frequency outside the legal window |

## Verification
The bench targets the unlock ordering. It covers a key broken by a read, by a wrong value, or by a write to another register. A design that commits anyway would show the new multiplier too early. A design that drops the pending values on abort would fail to commit them on the next clean key. A key with idle cycles inside it, and a repeated 0xAA, check that arming is neither lost nor too strict. The frequency flag is probed exactly at 156000 and 320000 and one step outside each, where an off-by-one comparison flips the flag. Read-back after a write without a key shows whether the port leaks pending values.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam int REG_CFG  = 0;
  localparam int REG_CTL  = 1;
  localparam int REG_FEED = 2;
  localparam int CTL_W    = 2;
  localparam int CTL_EN   = 0;
  localparam int CTL_CONN = 1;
endpackage

// File: rtl/pll_feed_unlock.sv
module pll_feed_unlock #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              feed_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              commit,
  output logic              armed_q
);
  import pll_cfg_pkg::*;

  logic key_a, key_b;
  always_comb begin
    key_a  = feed_wr && (wdata == DATA_W'(KEY_FIRST));
    key_b  = feed_wr && (wdata == DATA_W'(KEY_SECOND));
    commit = armed_q && key_b;
  end

  always_ff @(posedge clk) begin
    if (rst)      armed_q <= 1'b0;
    else if (acc) armed_q <= key_a;
  end

  // R3: any access other than the first key clears arming
  a_r3_abort_clears: assert property (@(posedge clk) disable iff (rst)
    (acc && !key_a) |=> !armed_q);
  // R2: arming only ever follows the first key value
  a_r2_arm_source: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(feed_wr && wdata == DATA_W'(KEY_FIRST)));
endmodule

// File: rtl/pll_shadow_regs.sv
module pll_shadow_regs #(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 7,
  parameter int CTL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              commit,
  output logic [CFG_W-1:0]  act_cfg,
  output logic [CTL_W-1:0]  act_ctl
);
  logic [CFG_W-1:0] shd_cfg;
  logic [CTL_W-1:0] shd_ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_cfg <= '0;
      shd_ctl <= '0;
      act_cfg <= '0;
      act_ctl <= '0;
    end else begin
      if (cfg_we) shd_cfg <= wdata[CFG_W-1:0];
      if (ctl_we) shd_ctl <= wdata[CTL_W-1:0];
      if (commit) begin
        act_cfg <= shd_cfg;
        act_ctl <= shd_ctl;
      end
    end
  end

  // R1: live values hold without a commit
  a_r1_live_hold: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(act_cfg) && $stable(act_ctl)));
  // R2: a commit copies the pending values
  a_r2_commit_copy: assert property (@(posedge clk) disable iff (rst)
    commit |=> (act_cfg == $past(shd_cfg) && act_ctl == $past(shd_ctl)));
endmodule

// File: rtl/pll_out_stage.sv
module pll_out_stage #(
  parameter int MULT_W   = 5,
  parameter int DIVC_W   = 2,
  parameter int CTL_W    = 2,
  parameter int OSC_W    = 20,
  parameter int FMIN_KHZ = 156000,
  parameter int FMAX_KHZ = 320000,
  localparam int CFG_W   = MULT_W + DIVC_W,
  localparam int MOUT_W  = MULT_W + 1,
  localparam int DOUT_W  = 2 ** DIVC_W,
  localparam int FREQ_W  = OSC_W + MOUT_W + DOUT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  act_cfg,
  input  logic [CTL_W-1:0]  act_ctl,
  input  logic              lock,
  input  logic [OSC_W-1:0]  osc_khz,
  output logic [MOUT_W-1:0] mult_q,
  output logic [DOUT_W-1:0] div_q,
  output logic              en_q,
  output logic              conn_q,
  output logic              bad_q
);
  import pll_cfg_pkg::*;

  logic [MOUT_W-1:0] mult_n;
  logic [DOUT_W-1:0] div_n;
  logic [FREQ_W-1:0] fcco;

  always_comb begin
    mult_n = MOUT_W'(act_cfg[MULT_W-1:0]) + MOUT_W'(1);
    div_n  = DOUT_W'(1) << act_cfg[CFG_W-1:MULT_W];
    fcco   = (FREQ_W'(osc_khz) * FREQ_W'(mult_n) * FREQ_W'(div_n)) << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mult_q <= MOUT_W'(1);
      div_q  <= DOUT_W'(1);
      en_q   <= 1'b0;
      conn_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      mult_q <= mult_n;
      div_q  <= div_n;
      en_q   <= act_ctl[CTL_EN];
      conn_q <= act_ctl[CTL_EN] && act_ctl[CTL_CONN] && lock;
      bad_q  <= (fcco < FREQ_W'(FMIN_KHZ)) || (fcco > FREQ_W'(FMAX_KHZ));
    end
  end

  // R8: connect never without enable
  a_r8_conn_needs_en: assert property (@(posedge clk) disable iff (rst)
    conn_q |-> en_q);
  // R5: divider is always a single power of two
  a_r5_div_pow2: assert property (@(posedge clk) disable iff (rst)
    $onehot(div_q));
  // R4: multiplier tracks the live code one clock later
  a_r4_mult_track: assert property (@(posedge clk) disable iff (rst)
    $stable(act_cfg) |=> $stable(mult_q));
endmodule

// File: rtl/pll_cfg_guard.sv
module pll_cfg_guard #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int MULT_W   = 5,
  parameter int DIVC_W   = 2,
  parameter int OSC_W    = 20,
  parameter int FMIN_KHZ = 156000,
  parameter int FMAX_KHZ = 320000,
  localparam int CFG_W   = MULT_W + DIVC_W,
  localparam int MOUT_W  = MULT_W + 1,
  localparam int DOUT_W  = 2 ** DIVC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [OSC_W-1:0]  osc_khz,
  input  logic              pll_lock,
  output logic [MOUT_W-1:0] pll_mult,
  output logic [DOUT_W-1:0] pll_div,
  output logic              pll_en,
  output logic              pll_conn,
  output logic              freq_bad
);
  import pll_cfg_pkg::*;

  logic             acc, cfg_we, ctl_we, feed_wr, commit, armed;
  logic [CFG_W-1:0] act_cfg;
  logic [CTL_W-1:0] act_ctl;

  always_comb begin
    acc     = bus_wr || bus_rd;
    cfg_we  = bus_wr && (bus_addr == ADDR_W'(REG_CFG));
    ctl_we  = bus_wr && (bus_addr == ADDR_W'(REG_CTL));
    feed_wr = bus_wr && (bus_addr == ADDR_W'(REG_FEED));
  end

  pll_feed_unlock #(.DATA_W(DATA_W)) u_unlock (
    .clk(clk), .rst(rst), .acc(acc), .feed_wr(feed_wr),
    .wdata(bus_wdata), .commit(commit), .armed_q(armed)
  );

  pll_shadow_regs #(.DATA_W(DATA_W), .CFG_W(CFG_W), .CTL_W(CTL_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .ctl_we(ctl_we),
    .wdata(bus_wdata), .commit(commit), .act_cfg(act_cfg), .act_ctl(act_ctl)
  );

  pll_out_stage #(
    .MULT_W(MULT_W), .DIVC_W(DIVC_W), .CTL_W(CTL_W), .OSC_W(OSC_W),
    .FMIN_KHZ(FMIN_KHZ), .FMAX_KHZ(FMAX_KHZ)
  ) u_out (
    .clk(clk), .rst(rst), .act_cfg(act_cfg), .act_ctl(act_ctl),
    .lock(pll_lock), .osc_khz(osc_khz), .mult_q(pll_mult), .div_q(pll_div),
    .en_q(pll_en), .conn_q(pll_conn), .bad_q(freq_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd && !bus_wr) begin
      if (bus_addr == ADDR_W'(REG_CFG))      bus_rdata <= DATA_W'(act_cfg);
      else if (bus_addr == ADDR_W'(REG_CTL)) bus_rdata <= DATA_W'(act_ctl);
      else                                   bus_rdata <= '0;
    end
  end

  // R9: configuration read-back shows the live value
  a_r9_read_live: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(REG_CFG)) |=>
      bus_rdata == DATA_W'($past(act_cfg)));
  // R3: a commit needs a prior arm, an unarmed second key commits nothing
  a_r3_unarmed_key: assert property (@(posedge clk) disable iff (rst)
    (!armed && feed_wr) |=> ($stable(act_cfg) && $stable(act_ctl)));
endmodule

// File: tb/sim_pll_cfg_guard.sv
module sim_pll_cfg_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [19:0] osc_khz = 20'd14746;
  logic       pll_lock = 1'b0;
  logic [5:0] pll_mult;
  logic [3:0] pll_div;
  logic       pll_en, pll_conn, freq_bad;

  int total = 0, bad = 0;
  logic [6:0] m_shd_cfg, m_act_cfg;
  logic [1:0] m_shd_ctl, m_act_ctl;
  bit         m_armed;

  always #10 clk = ~clk;

  pll_cfg_guard u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_khz(osc_khz),
    .pll_lock(pll_lock), .pll_mult(pll_mult), .pll_div(pll_div),
    .pll_en(pll_en), .pll_conn(pll_conn), .freq_bad(freq_bad)
  );

  function automatic logic exp_bad(input logic [19:0] osc, input logic [6:0] cfg);
    longint f;
    f = longint'(osc) * (longint'(cfg[4:0]) + 1) * 2 * (longint'(1) << cfg[6:5]);
    return (f < 156000) || (f > 320000);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 2'd0) m_shd_cfg = d[6:0];
    if (a == 2'd1) m_shd_ctl = d[1:0];
    if (a == 2'd2 && d == 8'h55 && m_armed) begin
      m_act_cfg = m_shd_cfg; m_act_ctl = m_shd_ctl;
    end
    m_armed = (a == 2'd2 && d == 8'hAA);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    m_armed = 1'b0;
  endtask

  task automatic chk_out(input string req);
    @(negedge clk);
    chk({req, " mult"}, pll_mult, longint'(m_act_cfg[4:0]) + 1);
    chk({req, " div"}, pll_div, longint'(1) << m_act_cfg[6:5]);
    chk({req, " en"}, pll_en, m_act_ctl[0]);
    chk({req, " conn"}, pll_conn, m_act_ctl[0] & m_act_ctl[1] & pll_lock);
    chk({req, " freq"}, freq_bad, exp_bad(osc_khz, m_act_cfg));
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int unsigned seed;
    m_shd_cfg = '0; m_act_cfg = '0; m_shd_ctl = '0; m_act_ctl = '0; m_armed = 0;
    seed = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 mult", pll_mult, 1);
    chk("R10 div", pll_div, 1);
    chk("R10 en", pll_en, 0);
    chk("R10 conn", pll_conn, 0);
    rd(2'd0, d); chk("R10 rdata", d, 0);

    // R1 pending writes do not show
    wr(2'd0, 8'h23); wr(2'd1, 8'h03); pll_lock = 1'b1;
    chk_out("R1");
    rd(2'd0, d); chk("R1 readback", d, 0);

    // R2 / R6 clean key with idle cycles inside
    wr(2'd2, 8'hAA); repeat (3) @(negedge clk); wr(2'd2, 8'h55);
    chk_out("R2");
    chk("R6 mult", pll_mult, 4);
    chk("R6 div", pll_div, 2);
    chk("R8 conn", pll_conn, 1);
    rd(2'd0, d); chk("R9 cfg read", d, 8'h23);
    rd(2'd1, d); chk("R9 ctl read", d, 8'h03);
    rd(2'd2, d); chk("R9 key read", d, 0);
    pll_lock = 1'b0; chk_out("R8 lock low");

    // R3 aborts keep pending values
    wr(2'd0, 8'h41);
    wr(2'd2, 8'hAA); rd(2'd1, d); wr(2'd2, 8'h55); chk_out("R3 read abort");
    chk("R3 read abort mult", pll_mult, 4);
    wr(2'd2, 8'hAA); wr(2'd2, 8'h56); wr(2'd2, 8'h55); chk_out("R3 value abort");
    wr(2'd2, 8'hAA); wr(2'd1, 8'h01); wr(2'd2, 8'h55); chk_out("R3 write abort");
    wr(2'd2, 8'hAA); wr(2'd2, 8'hAA); wr(2'd2, 8'h55); chk_out("R3 rearm");
    chk("R4 mult", pll_mult, 2);
    chk("R5 div", pll_div, 4);

    // R7 window edges: mult 4, div 1
    wr(2'd0, 8'h03); wr(2'd2, 8'hAA); wr(2'd2, 8'h55);
    osc_khz = 20'd19500; chk_out("R7 low edge");   chk("R7 at 156000", freq_bad, 0);
    osc_khz = 20'd19499; chk_out("R7 below");      chk("R7 below 156000", freq_bad, 1);
    osc_khz = 20'd40000; chk_out("R7 high edge");  chk("R7 at 320000", freq_bad, 0);
    osc_khz = 20'd40001; chk_out("R7 above");      chk("R7 above 320000", freq_bad, 1);

    // random mix checked against the model
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom % 8;
      osc_khz = 20'(2000 + $urandom % 60000);
      pll_lock = 1'($urandom);
      case (op)
        0: wr(2'd0, 8'($urandom));
        1: wr(2'd1, 8'($urandom));
        2, 3: wr(2'd2, 8'hAA);
        4: wr(2'd2, 8'h55);
        5: wr(2'(($urandom % 2) ? 2 : 3), 8'($urandom));
        6: begin
          rd(2'd0, d);
          chk("R9 random read", d, longint'(m_act_cfg));
        end
        default: @(negedge clk);
      endcase
      chk_out("R2 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule